// File: doc/BRIEF.md
# Memory Region Protection Rule Checker

This block screens every transaction headed for a memory controller and decides whether it may pass. It keeps a table of 20 protection rules. Each rule names a window of 1 MiB blocks, an inclusive range of transaction IDs, a set of ports and the security kinds it applies to, and says whether a match is accepted or rejected. Each incoming transaction carries an address, an ID, a port number and a secure flag. The block gives its accept/reject verdict combinationally, in the same cycle.

Software never writes a rule directly. It first loads three staging words: the block window, the ID range and the attribute word. It then writes the control register with a rule number and a commit bit, which copies the staged words into that rule. Setting the fetch bit instead copies a stored rule back into the staging words, where it can be read. A 10-bit default register, one bit per port, decides any transaction that no valid rule matches.

Top module: `region_guard`

## Requirements
- R1: After a synchronous active-low reset, every rule is invalid, the staging words read zero and the default register reads zero, so every transaction on a port below 10 is accepted.
- R2: A control write with bit 5 set and a rule number (bits 4:0) below 20 copies the three staged words into that rule, effective from the next cycle.
- R3: A control write with bit 6 set, bit 5 clear and a rule number below 20 loads that rule into the staging words, visible from the next cycle. When bits 5 and 6 are both set, the commit takes place and the staging words keep their values.
- R4: A control write whose rule number is 20 or above changes no rule and leaves the staging words unchanged.
- R5: Window word: bits 11:0 hold the first block and bits 23:12 hold the last block. A transaction is inside the window when address bits 31:20 lie between the two, both ends included.
- R6: ID word: bits 11:0 hold the lowest ID and bits 23:12 hold the highest. The transaction ID must lie between them, both ends included.
- R7: Attribute word: bit 0 lets secure traffic match, bit 1 lets non-secure traffic match, bit 2 marks the rule valid, bits 12:3 hold the port mask (bit 3+p for port p), and bit 13 is the result (1 rejects, 0 accepts).
- R8: When several rules match, the lowest-numbered one decides the verdict.
- R9: With no matching rule, the transaction is rejected exactly when its port's bit in the default register is 1.
- R10: A transaction on port 10 or above is always rejected.
- R11: Stored rules and the default register hold their values between writes. Changing the staging words without a commit leaves every verdict unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_i | input | 7 | Control value: rule number 4:0, commit 5, fetch 6 |
| win_wr_i | input | 1 | Write strobe for the staged window word |
| win_i | input | 24 | Window word to stage |
| ids_wr_i | input | 1 | Write strobe for the staged ID word |
| ids_i | input | 24 | ID word to stage |
| attr_wr_i | input | 1 | Write strobe for the staged attribute word |
| attr_i | input | 14 | Attribute word to stage |
| win_o | output | 24 | Staged window word |
| ids_o | output | 24 | Staged ID word |
| attr_o | output | 14 | Staged attribute word |
| dflt_wr_i | input | 1 | Default register write strobe |
| dflt_i | input | 10 | Default value, one bit per port |
| dflt_o | output | 10 | Current default register |
| txn_addr_i | input | 32 | Transaction byte address |
| txn_id_i | input | 12 | Transaction ID |
| txn_port_i | input | 4 | Transaction port number |
| txn_secure_i | input | 1 | 1 when the transaction is secure |
| reject_o | output | 1 | 1 rejects the transaction, 0 accepts it |

## Verification
The bench probes both ends of each window and ID range, and a block just below the window start. A comparison that is off by one at either end would flip the verdict there. The bench also covers a port outside the mask, the wrong security kind, two overlapping rules with opposite results, and a port number beyond the table. A design that let the higher-numbered rule win would accept where a reject is expected, and one that treated out-of-range ports as matchable would accept them. The bench also issues out-of-range commits and fetches, a commit and fetch in the same write, and staging changes with no commit. A design that wrapped the rule number, swapped the staging words on a combined strobe, or filtered live traffic through the staging words would each change an observable verdict or readback.

// File: rtl/region_guard_pkg.sv
// Package: shared widths and the stored rule layout for the region guard.
// Assumes: the field order below matches the software word layout, so a
// rule is the concatenation {window word, ID word, attribute word}.
package region_guard_pkg;
    localparam int BLK_W  = 12;   // width of a 1 MiB block index
    localparam int ID_W   = 12;   // width of a transaction ID
    localparam int NPORT  = 10;   // ports covered by masks and defaults
    localparam int ATTR_W = 4 + NPORT;
    localparam int WIN_W  = 2 * BLK_W;
    localparam int IDS_W  = 2 * ID_W;

    typedef struct packed {
        logic [BLK_W-1:0] last_blk;
        logic [BLK_W-1:0] first_blk;
        logic [ID_W-1:0]  id_hi;
        logic [ID_W-1:0]  id_lo;
        logic             deny;
        logic [NPORT-1:0] ports;
        logic             live;
        logic             nsec_en;
        logic             sec_en;
    } rule_t;
endpackage

// File: rtl/region_guard_bank.sv
// Module: rule table plus staging words, updated by commit and fetch strobes.
// Assumes: rule numbers at or above NUM_RULES are ignored; when commit and
// fetch arrive together, only the commit acts.
module region_guard_bank
    import region_guard_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int SEL_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             commit_i,
    input  logic             fetch_i,
    input  logic             win_wr_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             ids_wr_i,
    input  logic [IDS_W-1:0] ids_i,
    input  logic             attr_wr_i,
    input  logic [ATTR_W-1:0] attr_i,
    output rule_t            stage_o,
    output rule_t            rules_o [NUM_RULES]
);
    rule_t stage_q;
    rule_t fetched;
    logic  sel_ok;

    assign sel_ok  = (32'(sel_i) < NUM_RULES);
    assign stage_o = stage_q;

    // Selects the addressed rule for a fetch.
    always_comb begin
        fetched = '0;
        for (int i = 0; i < NUM_RULES; i++)
            if (32'(sel_i) == i) fetched = rules_o[i];
    end

    // One storage slot per rule, loaded only by a commit naming it.
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                rules_o[g] <= '0;
            else if (ctl_wr_i && commit_i && 32'(sel_i) == g)
                rules_o[g] <= stage_q;
        end
    end

    // Staging words: a fetch overrides any word writes in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (ctl_wr_i && fetch_i && !commit_i && sel_ok)
            stage_q <= fetched;
        else begin
            if (win_wr_i)  {stage_q.last_blk, stage_q.first_blk} <= win_i;
            if (ids_wr_i)  {stage_q.id_hi, stage_q.id_lo} <= ids_i;
            if (attr_wr_i) {stage_q.deny, stage_q.ports, stage_q.live,
                            stage_q.nsec_en, stage_q.sec_en} <= attr_i;
        end
    end

    // R4: an out-of-range control write with no word writes keeps staging
    a_r4_bad_sel_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && !sel_ok && !win_wr_i && !ids_wr_i && !attr_wr_i)
        |=> $stable(stage_q));

    // R3: a valid fetch shows the stored rule in staging on the next cycle
    a_r3_fetch_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && fetch_i && !commit_i && sel_ok) |=> (stage_q == $past(fetched)));

    // R3: commit with fetch leaves staging untouched
    a_r3_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && fetch_i && commit_i && !win_wr_i && !ids_wr_i && !attr_wr_i)
        |=> $stable(stage_q));
endmodule

// File: rtl/region_guard_match.sv
// Module: decides whether one rule covers a transaction.
// Assumes: port numbers at or above NPORT never match.
module region_guard_match
    import region_guard_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  rule_t             rule_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              secure_i,
    output logic              hit_o
);
    logic [NPORT-1:0] shifted;
    logic in_win, in_ids, port_ok, sec_ok;

    // Combines the window, ID, port and security tests of one rule.
    always_comb begin
        shifted = rule_i.ports >> port_i;
        in_win  = (blk_i >= rule_i.first_blk) && (blk_i <= rule_i.last_blk);
        in_ids  = (id_i >= rule_i.id_lo) && (id_i <= rule_i.id_hi);
        port_ok = (32'(port_i) < NPORT) && shifted[0];
        sec_ok  = secure_i ? rule_i.sec_en : rule_i.nsec_en;
        hit_o   = rule_i.live && in_win && in_ids && port_ok && sec_ok;
    end
endmodule

// File: rtl/region_guard_pick.sv
// Module: picks the lowest-numbered matching rule and reports its result.
// Assumes: deny_i[i] belongs to the rule behind hits_i[i].
module region_guard_pick #(
    parameter int NUM_RULES = 20,
    parameter int SEL_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RULES-1:0] hits_i,
    input  logic [NUM_RULES-1:0] deny_i,
    output logic                 any_o,
    output logic [SEL_W-1:0]     idx_o,
    output logic                 deny_o
);
    // Scans from the top so the lowest matching index is kept last.
    always_comb begin
        any_o  = 1'b0;
        idx_o  = '0;
        deny_o = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                any_o  = 1'b1;
                idx_o  = SEL_W'(i);
                deny_o = deny_i[i];
            end
        end
    end

    // R8: the chosen rule really matched
    a_r8_pick_hits: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> hits_i[idx_o]);

    // R8: no rule below the chosen one matched
    a_r8_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((hits_i & ((NUM_RULES'(1) << idx_o) - NUM_RULES'(1))) == '0));

    // R9: no verdict from the table when nothing matched
    a_r9_no_hit_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !any_o |-> (hits_i == '0));
endmodule

// File: rtl/region_guard.sv
// Module: top of the rule-based access filter in front of a memory controller.
// Assumes: the verdict is combinational in the transaction inputs; rule and
// default updates take effect the cycle after their write.
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NUM_RULES = 20,
    parameter int ADDR_W    = 32,
    parameter int PORT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic [6:0]        ctl_i,
    input  logic              win_wr_i,
    input  logic [23:0]       win_i,
    input  logic              ids_wr_i,
    input  logic [23:0]       ids_i,
    input  logic              attr_wr_i,
    input  logic [13:0]       attr_i,
    output logic [23:0]       win_o,
    output logic [23:0]       ids_o,
    output logic [13:0]       attr_o,
    input  logic              dflt_wr_i,
    input  logic [9:0]        dflt_i,
    output logic [9:0]        dflt_o,
    input  logic [ADDR_W-1:0] txn_addr_i,
    input  logic [11:0]       txn_id_i,
    input  logic [PORT_W-1:0] txn_port_i,
    input  logic              txn_secure_i,
    output logic              reject_o
);
    localparam int SEL_W = 5;
    localparam int BLK_LSB = ADDR_W - BLK_W;

    rule_t                 stage;
    rule_t                 rules [NUM_RULES];
    logic [NUM_RULES-1:0]  hits, denies;
    logic                  any_hit, pick_deny;
    logic [SEL_W-1:0]      pick_idx;
    logic [NPORT-1:0]      dflt_q, dflt_sh;
    logic [BLK_W-1:0]      blk;

    assign blk = txn_addr_i[ADDR_W-1:BLK_LSB];

    region_guard_bank #(.NUM_RULES(NUM_RULES), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr_i), .sel_i(ctl_i[4:0]),
        .commit_i(ctl_i[5]), .fetch_i(ctl_i[6]),
        .win_wr_i(win_wr_i), .win_i(win_i),
        .ids_wr_i(ids_wr_i), .ids_i(ids_i),
        .attr_wr_i(attr_wr_i), .attr_i(attr_i),
        .stage_o(stage), .rules_o(rules)
    );

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        region_guard_match #(.PORT_W(PORT_W)) u_match (
            .rule_i(rules[g]), .blk_i(blk), .id_i(txn_id_i),
            .port_i(txn_port_i), .secure_i(txn_secure_i), .hit_o(hits[g])
        );
        assign denies[g] = rules[g].deny;
    end

    region_guard_pick #(.NUM_RULES(NUM_RULES), .SEL_W(SEL_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .hits_i(hits), .deny_i(denies),
        .any_o(any_hit), .idx_o(pick_idx), .deny_o(pick_deny)
    );

    // Default register: one reject bit per port for unmatched traffic.
    always_ff @(posedge clk) begin
        if (!rst_n)         dflt_q <= '0;
        else if (dflt_wr_i) dflt_q <= dflt_i;
    end

    // Verdict: bad port rejects, else the picked rule, else the port default.
    always_comb begin
        dflt_sh = dflt_q >> txn_port_i;
        if (32'(txn_port_i) >= NPORT) reject_o = 1'b1;
        else if (any_hit)             reject_o = pick_deny;
        else                          reject_o = dflt_sh[0];
    end

    assign win_o  = {stage.last_blk, stage.first_blk};
    assign ids_o  = {stage.id_hi, stage.id_lo};
    assign attr_o = {stage.deny, stage.ports, stage.live, stage.nsec_en, stage.sec_en};
    assign dflt_o = dflt_q;

    // R10: ports beyond the table are always rejected
    a_r10_bad_port: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(txn_port_i) >= NPORT) |-> reject_o);

    // R11: the default register holds between writes
    a_r11_dflt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dflt_wr_i |=> $stable(dflt_o));

    // R9: an unmatched in-range port follows its default bit
    a_r9_default_used: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_hit && 32'(txn_port_i) < NPORT) |-> (reject_o == dflt_sh[0]));
endmodule

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, win_wr = 0, ids_wr = 0, attr_wr = 0, dflt_wr = 0;
    logic [6:0]  ctl = '0;
    logic [23:0] win = '0, ids = '0;
    logic [13:0] attr = '0;
    logic [9:0]  dflt = '0;
    logic [23:0] win_o, ids_o;
    logic [13:0] attr_o;
    logic [9:0]  dflt_o;
    logic [31:0] addr = '0;
    logic [11:0] id = '0;
    logic [3:0]  port = '0;
    logic        sec = 1'b0;
    logic        reject;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    region_guard u_region_guard (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_i(ctl_wr), .ctl_i(ctl),
        .win_wr_i(win_wr), .win_i(win), .ids_wr_i(ids_wr), .ids_i(ids),
        .attr_wr_i(attr_wr), .attr_i(attr),
        .win_o(win_o), .ids_o(ids_o), .attr_o(attr_o),
        .dflt_wr_i(dflt_wr), .dflt_i(dflt), .dflt_o(dflt_o),
        .txn_addr_i(addr), .txn_id_i(id), .txn_port_i(port),
        .txn_secure_i(sec), .reject_o(reject)
    );

    // Vector: {addr, id, port, secure, expected reject}
    // Rule 3: blocks 0x010..0x01F, IDs 0..0xFF, ports 0-1, both kinds, reject.
    // Rule 7: blocks 0x000..0x0FF, any ID, all ports, secure only, accept.
    // Default 0x3F0: ports 4..9 reject when unmatched.
    localparam logic [49:0] VEC [11] = '{
        {32'h0100_0000, 12'h005, 4'd0,  1'b1, 1'b1},  // R8 rule 3 beats rule 7
        {32'h01F0_0000, 12'h0FF, 4'd1,  1'b0, 1'b1},  // R5 R6 upper ends included
        {32'h0200_0000, 12'h005, 4'd0,  1'b1, 1'b0},  // R7 rule 7 secure accept
        {32'h0200_0000, 12'h005, 4'd5,  1'b0, 1'b1},  // R7 R9 non-secure falls to default
        {32'h0200_0000, 12'h005, 4'd5,  1'b1, 1'b0},  // R9 rule overrides default
        {32'h0100_0000, 12'h100, 4'd0,  1'b1, 1'b0},  // R6 ID above range
        {32'h0100_0000, 12'h005, 4'd2,  1'b1, 1'b0},  // R7 port outside mask
        {32'h00F0_0000, 12'h005, 4'd1,  1'b1, 1'b0},  // R5 block below start
        {32'h1000_0000, 12'h005, 4'd6,  1'b1, 1'b1},  // R9 past rule 7 window
        {32'h0100_0000, 12'h005, 4'd12, 1'b1, 1'b1},  // R10 port beyond table
        {32'h3000_0000, 12'h005, 4'd3,  1'b0, 1'b0}   // R9 default accept bit
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic stage_words(input logic [23:0] w, input logic [23:0] i, input logic [13:0] a);
        @(negedge clk);
        win = w; ids = i; attr = a; win_wr = 1; ids_wr = 1; attr_wr = 1;
        @(negedge clk);
        win_wr = 0; ids_wr = 0; attr_wr = 0;
    endtask

    task automatic control(input logic [6:0] c);
        @(negedge clk);
        ctl = c; ctl_wr = 1;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic set_default(input logic [9:0] d);
        @(negedge clk);
        dflt = d; dflt_wr = 1;
        @(negedge clk);
        dflt_wr = 0;
    endtask

    task automatic probe(input string req, input logic [31:0] a, input logic [11:0] i,
                         input logic [3:0] p, input logic s, input logic exp);
        @(negedge clk);
        addr = a; id = i; port = p; sec = s;
        #1;
        chk(req, {31'd0, reject}, {31'd0, exp});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 window word", {8'd0, win_o}, 32'd0);
        chk("R1 attribute word", {18'd0, attr_o}, 32'd0);
        chk("R1 default", {22'd0, dflt_o}, 32'd0);
        probe("R1 accept after reset", 32'h0100_0000, 12'h005, 4'd5, 1'b0, 1'b0);

        // R2: program rules 3 and 7 (commit = bit 5)
        stage_words(24'h01F010, 24'h0FF000, 14'h201F);
        control(7'b0100011);
        stage_words(24'h0FF000, 24'hFFF000, 14'h1FFD);
        control(7'b0100111);
        set_default(10'h3F0);
        chk("R11 default readback", {22'd0, dflt_o}, 32'h3F0);

        for (int v = 0; v < 11; v++)
            probe($sformatf("R2 table vector %0d", v), VEC[v][49:18], VEC[v][17:6],
                  VEC[v][5:2], VEC[v][1], VEC[v][0]);

        // R11: reject-all staged but not committed changes nothing
        stage_words(24'hFFF000, 24'hFFF000, 14'h3FFF);
        probe("R11 staging alone", 32'h0200_0000, 12'h005, 4'd0, 1'b1, 1'b0);

        // R4: commits to rules 20 and 25 are ignored
        control(7'b0110100);
        control(7'b0111001);
        probe("R4 commit out of range", 32'h0200_0000, 12'h005, 4'd0, 1'b1, 1'b0);
        control(7'b1011001);
        chk("R4 fetch out of range", {18'd0, attr_o}, 32'h3FFF);

        // R3: fetch rule 3 back into staging
        control(7'b1000011);
        chk("R3 fetched window", {8'd0, win_o}, 32'h01F010);
        chk("R3 fetched IDs", {8'd0, ids_o}, 32'h0FF000);
        chk("R3 fetched attributes", {18'd0, attr_o}, 32'h201F);

        // R3: commit and fetch together on rule 0 keeps staging
        stage_words(24'hFFF000, 24'hFFF000, 14'h3FFF);
        control(7'b1100000);
        chk("R3 combined strobe staging", {18'd0, attr_o}, 32'h3FFF);
        probe("R8 rule 0 now wins", 32'h0200_0000, 12'h005, 4'd0, 1'b1, 1'b1);

        // R2: clearing rule 0 restores rule 7's verdict
        stage_words(24'h0, 24'h0, 14'h0);
        control(7'b0100000);
        probe("R2 cleared rule", 32'h0200_0000, 12'h005, 4'd0, 1'b1, 1'b0);

        // R9: default cleared, unmatched port 6 now accepted
        set_default(10'h000);
        probe("R9 default zero", 32'h1000_0000, 12'h005, 4'd6, 1'b1, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule